// File: doc/BRIEF.md
# Packed Byte Sum-of-Absolute-Differences Unit

This block is a two-stage SIMD datapath. It takes two 256-bit operands, each made of unsigned bytes, and forms the magnitude of the difference of every byte pair. It then adds those magnitudes eight at a time, one group for each 64-bit lane. Each group total is written as a zero-extended 16-bit word at the bottom of its lane, and the rest of the lane is cleared.

A 2-bit mode input sets how many lanes carry a result. One mode uses one lane and two modes use two lanes. The two-lane modes differ in the upper half of the result: one copies it from the current destination value and the other clears it. The fourth mode uses all four lanes. The mode and the destination value travel down the pipeline with their own operation, so a new operation can be issued on every cycle.

The result is registered. It appears, together with a valid strobe, two clock edges after the operation is accepted. Between operations the result holds its last value.

Top module: `sad_unit`

## Requirements
- R1: For every active lane L, result bits [L*64+15 : L*64] hold the sum over k=0..7 of |a[byte 8L+k] - b[byte 8L+k]|, with every byte read as unsigned. Byte n occupies bits [8n+7:8n].
- R2: In every mode other than 2'b01, bits [63:16] of each lane are zero. In mode 2'b01 this applies to lanes 0 and 1.
- R3: Mode 2'b00 (64-bit) makes lane 0 the only active lane, and result bits [255:64] are zero.
- R4: Modes 2'b01 and 2'b10 (128-bit) make lanes 0 and 1 active. Their sums appear at bits [15:0] and [79:64].
- R5: In mode 2'b01, result bits [255:128] equal dest_i[255:128] as sampled when the operation was accepted.
- R6: In mode 2'b10, result bits [255:128] are zero.
- R7: Mode 2'b11 (256-bit) makes all four lanes active, with sums at bit offsets 0, 64, 128 and 192.
- R8: No lane sum exceeds 2040. The largest case, 0x00 against 0xFF in all eight bytes of a lane, gives exactly 2040 with no wrap.
- R9: Swapping a_i and b_i leaves the result unchanged.
- R10: valid_o rises exactly two rising clock edges after an edge that samples valid_i high. Back-to-back operations give back-to-back results. Reset drives valid_o and result_o to zero.
- R11: result_o keeps its value on every edge at which no operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation accepted on this edge |
| mode_i | input | 2 | 00 64-bit, 01 128-bit keep upper, 10 128-bit clear upper, 11 256-bit |
| a_i | input | 256 | First byte vector |
| b_i | input | 256 | Second byte vector |
| dest_i | input | 256 | Current destination value (upper half is used in mode 01) |
| valid_o | output | 1 | Result valid |
| result_o | output | 256 | Registered result |

## Verification
The case most likely to go wrong is two operations in flight at once. One operation can be forming its sums while another operation with a different mode is being assembled at the output. If mode or destination data were not staged with their own operation, one operation could take its upper-half treatment from its neighbour.

The bench provokes this by streaming operations back to back. Modes and destination values are random, so a pass-through operation often sits right next to a clearing one. On every clock, each output is compared with a behavioural model that is staged two edges deep.

Directed cases add all-equal operands, the 0x00 against 0xFF extreme, operand swapping and idle hold.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [1:0] {
    MODE_W64      = 2'b00,
    MODE_W128_KEEP = 2'b01,
    MODE_W128_CLR  = 2'b10,
    MODE_W256     = 2'b11
  } sad_mode_e;
endpackage

// File: rtl/sad_lane_s1.sv
// Stage 1: byte magnitudes and first adder level, registered.
module sad_lane_s1 #(
  parameter int LANE_BYTES = 8,
  parameter int BYTE_W     = 8,
  localparam int LANE_W    = LANE_BYTES * BYTE_W,
  localparam int PART_N    = LANE_BYTES / 2,
  localparam int PART_W    = BYTE_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [LANE_W-1:0]        a_i,
  input  logic [LANE_W-1:0]        b_i,
  output logic [PART_N*PART_W-1:0] part_o
);
  logic [BYTE_W-1:0]        diff [LANE_BYTES];
  logic [PART_N*PART_W-1:0] part_d;

  for (genvar j = 0; j < LANE_BYTES; j++) begin : g_diff
    logic [BYTE_W-1:0] x, y;
    assign x = a_i[j*BYTE_W +: BYTE_W];
    assign y = b_i[j*BYTE_W +: BYTE_W];
    assign diff[j] = (x > y) ? (x - y) : (y - x);
  end

  for (genvar p = 0; p < PART_N; p++) begin : g_pair
    assign part_d[p*PART_W +: PART_W] = {1'b0, diff[2*p]} + {1'b0, diff[2*p+1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   part_o <= '0;
    else if (en_i) part_o <= part_d;
  end
endmodule

// File: rtl/sad_lane_s2.sv
// Stage 2 reduction: remaining adder levels, zero-extended.
module sad_lane_s2 #(
  parameter int LANE_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int SUM_W      = 16,
  localparam int PART_N    = LANE_BYTES / 2,
  localparam int PART_W    = BYTE_W + 1,
  localparam int ACC_W     = BYTE_W + $clog2(LANE_BYTES)
) (
  input  logic [PART_N*PART_W-1:0] part_i,
  output logic [SUM_W-1:0]         sum_o
);
  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int p = 0; p < PART_N; p++)
      acc = acc + ACC_W'(part_i[p*PART_W +: PART_W]);
  end

  assign sum_o = SUM_W'(acc);
endmodule

// File: rtl/sad_assemble.sv
// Result assembly and output register.
module sad_assemble
  import sad_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int LANE_W     = 64,
  parameter int SUM_W      = 16,
  localparam int DATA_W    = LANES * LANE_W,
  localparam int HI_LO     = 2 * LANE_W,
  localparam int HI_W      = DATA_W - HI_LO
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  sad_mode_e              mode_i,
  input  logic [HI_W-1:0]        dest_hi_i,
  input  logic [LANES*SUM_W-1:0] sums_i,
  output logic                   valid_o,
  output logic [DATA_W-1:0]      result_o
);
  logic [DATA_W-1:0] res_d;
  int unsigned       n_active;

  always_comb begin
    unique case (mode_i)
      MODE_W64:  n_active = 1;
      MODE_W256: n_active = LANES;
      default:   n_active = 2;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l < 2) begin : g_low
      assign res_d[l*LANE_W +: LANE_W] = (l < n_active) ?
             LANE_W'(sums_i[l*SUM_W +: SUM_W]) : '0;
    end else begin : g_high
      assign res_d[l*LANE_W +: LANE_W] =
             (mode_i == MODE_W128_KEEP) ? dest_hi_i[(l-2)*LANE_W +: LANE_W] :
             (l < n_active) ? LANE_W'(sums_i[l*SUM_W +: SUM_W]) : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end

  AST_KEEP_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == MODE_W128_KEEP |=> result_o[DATA_W-1:HI_LO] == $past(dest_hi_i)); // R5
  AST_CLR_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == MODE_W128_CLR |=> result_o[DATA_W-1:HI_LO] == '0); // R6
  AST_W64_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == MODE_W64 |=> result_o[DATA_W-1:LANE_W] == '0); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R11
  AST_OUT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R10

  for (genvar l = 0; l < LANES; l++) begin : g_pad_chk
    AST_LANE_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && (mode_i != MODE_W128_KEEP || l < 2)
      |=> result_o[l*LANE_W+SUM_W +: LANE_W-SUM_W] == '0); // R2
  end
endmodule

// File: rtl/sad_unit.sv
module sad_unit
  import sad_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int LANE_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int SUM_W      = 16,
  localparam int LANE_W    = LANE_BYTES * BYTE_W,
  localparam int DATA_W    = LANES * LANE_W,
  localparam int HI_W      = DATA_W - 2 * LANE_W,
  localparam int PART_N    = LANE_BYTES / 2,
  localparam int PART_W    = BYTE_W + 1,
  localparam int SUM_MAX   = LANE_BYTES * ((1 << BYTE_W) - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] dest_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic                   valid_s1;
  sad_mode_e              mode_s1;
  logic [HI_W-1:0]        dest_hi_s1;
  logic [LANES*SUM_W-1:0] sums;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_s1   <= 1'b0;
      mode_s1    <= MODE_W64;
      dest_hi_s1 <= '0;
    end else begin
      valid_s1 <= valid_i;
      if (valid_i) begin
        mode_s1    <= sad_mode_e'(mode_i);
        dest_hi_s1 <= dest_i[DATA_W-1:2*LANE_W];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PART_N*PART_W-1:0] part;

    sad_lane_s1 #(.LANE_BYTES(LANE_BYTES), .BYTE_W(BYTE_W)) u_s1 (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (valid_i),
      .a_i    (a_i[l*LANE_W +: LANE_W]),
      .b_i    (b_i[l*LANE_W +: LANE_W]),
      .part_o (part)
    );

    sad_lane_s2 #(.LANE_BYTES(LANE_BYTES), .BYTE_W(BYTE_W), .SUM_W(SUM_W)) u_s2 (
      .part_i (part),
      .sum_o  (sums[l*SUM_W +: SUM_W])
    );

    AST_SUM_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_s1 |-> sums[l*SUM_W +: SUM_W] <= SUM_W'(SUM_MAX)); // R8
  end

  sad_assemble #(.LANES(LANES), .LANE_W(LANE_W), .SUM_W(SUM_W)) u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_s1),
    .mode_i    (mode_s1),
    .dest_hi_i (dest_hi_s1),
    .sums_i    (sums),
    .valid_o   (valid_o),
    .result_o  (result_o)
  );

  AST_S1_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_s1); // R10
  AST_S1_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_s1); // R10
endmodule

// File: tb/tb_sad_unit.sv
`timescale 1ns/1ps
module tb_sad_unit;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic [255:0] a_i = '0, b_i = '0, dest_i = '0;
  logic         valid_o;
  logic [255:0] result_o;

  int n_cmp = 0, n_bad = 0;
  bit model_on = 0;

  always #2 clk = ~clk;

  sad_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .a_i(a_i), .b_i(b_i), .dest_i(dest_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [255:0] ref_sad(input logic [255:0] a, input logic [255:0] b,
                                           input logic [255:0] d, input logic [1:0] m);
    logic [255:0] r = '0;
    int lanes = (m == 2'b00) ? 1 : (m == 2'b11) ? 4 : 2;
    for (int l = 0; l < lanes; l++) begin
      int s = 0;
      for (int k = 0; k < 8; k++) begin
        int x = int'(a[(l*8+k)*8 +: 8]);
        int y = int'(b[(l*8+k)*8 +: 8]);
        s += (x > y) ? x - y : y - x;
      end
      r[l*64 +: 16] = 16'(s);
    end
    if (m == 2'b01) r[255:128] = d[255:128];
    return r;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R4/R5";
      2'b10:   return "R4/R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // cycle-level reference: two stages, output held between ops
  logic         m_v1 = 0, m_vo = 0;
  logic [255:0] m_r1 = '0, m_ro = '0;
  logic [1:0]   m_m1 = 0, m_mo = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_v1 = 0; m_vo = 0; m_ro = '0;
    end else begin
      if (m_v1) begin m_ro = m_r1; m_mo = m_m1; end
      m_vo = m_v1;
      m_v1 = valid_i;
      if (valid_i) begin m_r1 = ref_sad(a_i, b_i, dest_i, mode_i); m_m1 = mode_i; end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_ni) begin
      check("R10 valid_o", 256'(valid_o), 256'(m_vo));
      check({mode_tag(m_mo), " R11 result_o"}, result_o, m_ro);
    end
  end

  task automatic run_op(input logic [255:0] a, input logic [255:0] b, input logic [255:0] d,
                        input logic [1:0] m, output logic [255:0] r);
    a_i = a; b_i = b; dest_i = d; mode_i = m; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    r = result_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] r, r2, a, b, d;
    repeat (3) @(negedge clk);
    check("R10 reset valid_o", 256'(valid_o), 256'(0));
    check("R10 reset result_o", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    model_on = 1;

    // R1: equal operands give zero sums
    a = rnd256();
    run_op(a, a, rnd256(), 2'b11, r);
    check("R1 equal operands", r, '0);

    // R8: extreme difference gives 2040 per lane
    run_op('0, {256{1'b1}}, '0, 2'b11, r);
    check("R8 max sum", r, {4{48'h0, 16'd2040}});
    run_op({256{1'b1}}, '0, '0, 2'b00, r);
    check("R8 max sum 64-bit", r, {192'h0, 48'h0, 16'd2040});

    // R1: single byte difference in each lane
    a = '0; b = '0;
    a[7:0] = 8'd3; b[7:0] = 8'd10; a[71:64] = 8'd200; b[71:64] = 8'd1;
    a[135:128] = 8'd5; a[199:192] = 8'd7; b[207:200] = 8'd9;
    run_op(a, b, '0, 2'b11, r);
    check("R1 R7 per-lane", r, {48'h0, 16'd16, 48'h0, 16'd5, 48'h0, 16'd199, 48'h0, 16'd7});

    // R5 / R6 / R3 upper-half treatment
    d = rnd256();
    a = rnd256(); b = rnd256();
    run_op(a, b, d, 2'b01, r);
    check("R5 keep upper", {128'h0, r[255:128]}, {128'h0, d[255:128]});
    check("R4 low lanes keep", {128'h0, r[127:0]}, {128'h0, ref_sad(a, b, d, 2'b10)});
    run_op(a, b, d, 2'b10, r);
    check("R6 clear upper", {128'h0, r[255:128]}, '0);
    run_op(a, b, d, 2'b00, r);
    check("R3 64-bit upper", {64'h0, r[255:64]}, '0);
    run_op(a, b, d, 2'b11, r);
    check("R2 lane pad", {r[255:208], r[191:144], r[127:80], r[63:16]}, '0);

    // R9: swapped operands
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m = 2'($urandom);
      a = rnd256(); b = rnd256(); d = rnd256();
      run_op(a, b, d, m, r);
      run_op(b, a, d, m, r2);
      check("R9 swap", r2, r);
    end

    // R11: idle inputs change, result holds
    run_op(rnd256(), rnd256(), rnd256(), 2'b11, r);
    for (int i = 0; i < 5; i++) begin
      a_i = rnd256(); b_i = rnd256(); dest_i = rnd256(); mode_i = 2'($urandom);
      @(negedge clk);
    end
    check("R11 hold", result_o, r);

    // streaming: mixed modes back to back, occasional gaps
    for (int i = 0; i < 400; i++) begin
      a_i = rnd256(); b_i = rnd256(); dest_i = rnd256(); mode_i = 2'($urandom);
      if ($urandom % 4 == 0) begin
        for (int k = 0; k < 8; k++) begin
          a_i[(k+8*($urandom%4))*8 +: 8] = 8'h00;
          b_i[(k+8*($urandom%4))*8 +: 8] = 8'hFF;
        end
      end
      valid_i = ($urandom % 5) != 0;
      @(negedge clk);
    end
    valid_i = 1'b0;
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule